// File: doc/BRIEF.md
# Processor interrupt input conditioner

This block sits between the four interrupt pins of a small 8/16-bit processor core and that core's instruction sequencer. All four pins are active low: a reset line, a non-maskable line, a maskable line and an abort line. Each pin is asynchronous to the core clock, so it first passes through a multi-flop synchroniser. After that, the reset, abort and maskable lines are sampled as levels. The non-maskable line is edge-sensed: a falling edge sets a latch, and that latch stays set until the sequencer strobes an acknowledge.

The block owns the 16-bit processor flags word. The sequencer can read the word at any time and can reload it as a whole, for example when it restores context after a handler. One bit of the word is the interrupt-enable flag, and that flag gates only the maskable class. The block reports every eligible request in a pending vector. It also reports a single winner, chosen by fixed priority, as a request-valid bit and a 2-bit class code.

Top module: `intc_cond`

## Requirements
- R1: After the system reset `rst_n` is released, and with all pins high, `req_valid` is 0, `pend_vec` is 0 and `flags_q` is 0.
- R2: Each pin passes through a synchroniser of SYNC_STAGES flops (default 2). A level change on a pin is not visible on `pend_vec` after one clock edge, and is visible after SYNC_STAGES edges.
- R3: While the reset pin is low, `pend_vec[0]` is 1 and the winner code is 0.
- R4: A single falling edge on the non-maskable pin sets `pend_vec[2]`. Holding the pin low after the latch is acknowledged does not produce a second request.
- R5: Once set, `pend_vec[2]` stays 1 until `nmi_ack` is sampled high, even if the pin returns high in the meantime.
- R6: A falling edge that is detected in the same cycle that `nmi_ack` is sampled leaves the latch set.
- R7: `pend_vec[3]` equals the maskable pin being low AND flags bit IE_BIT (default bit 2) being 1. While the flag is 0, the maskable request is held off and is not lost.
- R8: A cycle with `flags_wr_en` high loads `flags_wr_data` into `flags_q` as a whole word. Restoring the word therefore also restores the mask state.
- R9: `pend_vec[1]` follows the abort pin being low, whatever the value of the enable flag.
- R10: The winner is chosen by fixed priority, reset > abort > non-maskable > maskable, with codes 0, 1, 2 and 3 in that order. `req_valid` is 1 exactly when any bit of `pend_vec` is 1.
- R11: A synchronised low on the reset pin clears the non-maskable latch and flags bit IE_BIT, takes precedence over a flags load to that bit, and leaves the other flags bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| pin_rst_n | input | 1 | Raw reset interrupt pin, active low, level |
| pin_abt_n | input | 1 | Raw abort pin, active low, level, not maskable |
| pin_nmi_n | input | 1 | Raw non-maskable pin, active low, falling edge |
| pin_irq_n | input | 1 | Raw maskable pin, active low, level |
| nmi_ack | input | 1 | Acknowledge strobe that clears the non-maskable latch |
| flags_wr_en | input | 1 | Load strobe for the flags word |
| flags_wr_data | input | 16 | Flags word to load |
| flags_q | output | 16 | Current flags word |
| req_valid | output | 1 | At least one request is eligible |
| req_kind | output | 2 | Winning class: 0 reset, 1 abort, 2 non-maskable, 3 maskable |
| pend_vec | output | 4 | Eligible requests: bit 0 reset, 1 abort, 2 non-maskable, 3 maskable |

## Verification
The hardest case to reach is a new falling edge on the non-maskable line that arrives in the same clock in which the sequencer acknowledges the previous one. The bench sets this up in a fixed order. It first sets the latch, releases the pin and lets the synchroniser settle. It then drops the pin and counts exactly the synchroniser edges, so that the acknowledge strobe lines up with the detection cycle. After that, the latch must still read set. Random rounds then mix reset, abort, the maskable level, the enable flag and fresh edges, so that priority and masking are covered under overlap.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NCLS = 4;
  localparam int KW   = $clog2(NCLS);

  typedef enum logic [KW-1:0] {
    K_RST = 2'd0,
    K_ABT = 2'd1,
    K_NMI = 2'd2,
    K_IRQ = 2'd3
  } kind_e;

  // lowest set index wins; index order is the priority order
  function automatic kind_e pick_winner(input logic [NCLS-1:0] p);
    kind_e k;
    k = K_IRQ;
    for (int i = NCLS - 1; i >= 0; i--) begin
      if (p[i]) k = kind_e'(i[KW-1:0]);
    end
    return k;
  endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '1;
        else        stg[i] <= din;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '1;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/intc_nmi_latch.sv
module intc_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_n,
  input  logic ack,
  input  logic clr,
  output logic fall,
  output logic lat
);
  logic prev_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_n <= 1'b1;
    else        prev_n <= lvl_n;
  end

  assign fall = prev_n & ~lvl_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lat <= 1'b0;
    else if (clr) lat <= 1'b0;
    else          lat <= (lat & ~ack) | fall;
  end

  // R4 R6
  nmi_edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall && !clr |=> lat);
  // R5
  nmi_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat && !ack && !clr |=> lat);
  // R11
  nmi_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !lat);
endmodule

// File: rtl/intc_flags.sv
module intc_flags #(
  parameter int FW     = 16,
  parameter int IE_BIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [FW-1:0] wr_data,
  input  logic          clr_ie,
  output logic [FW-1:0] flags,
  output logic          ie
);
  localparam logic [FW-1:0] IE_MASK = FW'(1) << IE_BIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      if (wr_en)  flags <= clr_ie ? (wr_data & ~IE_MASK) : wr_data;
      else if (clr_ie) flags <= flags & ~IE_MASK;
    end
  end

  assign ie = flags[IE_BIT];

  // R11
  ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ie |=> !ie);
  // R8
  flags_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !clr_ie |=> flags == $past(wr_data));
endmodule

// File: rtl/intc_cond.sv
module intc_cond #(
  parameter int FW          = 16,
  parameter int IE_BIT      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_rst_n,
  input  logic          pin_abt_n,
  input  logic          pin_nmi_n,
  input  logic          pin_irq_n,
  input  logic          nmi_ack,
  input  logic          flags_wr_en,
  input  logic [FW-1:0] flags_wr_data,
  output logic [FW-1:0] flags_q,
  output logic          req_valid,
  output logic [1:0]    req_kind,
  output logic [3:0]    pend_vec
);
  import intc_pkg::*;

  logic [NCLS-1:0] pins_s_n;
  logic            rst_req, abt_req, irq_lvl, nmi_fall, nmi_lat, ie;
  kind_e           win;

  intc_sync #(.W(NCLS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n),
    .din ({pin_irq_n, pin_nmi_n, pin_abt_n, pin_rst_n}),
    .dout(pins_s_n)
  );

  assign rst_req = ~pins_s_n[0];
  assign abt_req = ~pins_s_n[1];
  assign irq_lvl = ~pins_s_n[3];

  intc_nmi_latch u_nmi (
    .clk (clk), .rst_n (rst_n), .lvl_n (pins_s_n[2]),
    .ack (nmi_ack), .clr (rst_req), .fall (nmi_fall), .lat (nmi_lat)
  );

  intc_flags #(.FW(FW), .IE_BIT(IE_BIT)) u_flags (
    .clk (clk), .rst_n (rst_n), .wr_en (flags_wr_en),
    .wr_data (flags_wr_data), .clr_ie (rst_req),
    .flags (flags_q), .ie (ie)
  );

  assign pend_vec  = {irq_lvl & ie, nmi_lat, abt_req, rst_req};
  assign win       = pick_winner(pend_vec);
  assign req_kind  = win;
  assign req_valid = |pend_vec;

  // R10
  rst_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vec[0] |-> req_kind == 2'd0 && req_valid);
  // R10
  abt_over_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vec[1] && !pend_vec[0] |-> req_kind == 2'd1);
  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_q[IE_BIT] |-> !pend_vec[3]);
  // R9
  abt_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_s_n[1] |-> pend_vec[1]);
  // R4
  nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(nmi_ack) && !$past(nmi_fall) && !nmi_fall && !$past(rst_req) |-> !nmi_lat);
endmodule

// File: tb/intc_cond_bench.sv
module intc_cond_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_rst_n = 1'b1, pin_abt_n = 1'b1, pin_nmi_n = 1'b1, pin_irq_n = 1'b1;
  logic        nmi_ack = 1'b0, flags_wr_en = 1'b0;
  logic [15:0] flags_wr_data = '0;
  logic [15:0] flags_q;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [3:0]  pend_vec;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  intc_cond u_intc_cond (
    .clk (clk), .rst_n (rst_n), .pin_rst_n (pin_rst_n), .pin_abt_n (pin_abt_n),
    .pin_nmi_n (pin_nmi_n), .pin_irq_n (pin_irq_n), .nmi_ack (nmi_ack),
    .flags_wr_en (flags_wr_en), .flags_wr_data (flags_wr_data), .flags_q (flags_q),
    .req_valid (req_valid), .req_kind (req_kind), .pend_vec (pend_vec)
  );

  function automatic logic [1:0] exp_kind(input logic [3:0] p);
    if (p[0]) return 2'd0;
    if (p[1]) return 2'd1;
    if (p[2]) return 2'd2;
    return 2'd3;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ack_pulse();
    nmi_ack = 1'b1; cyc(1); nmi_ack = 1'b0;
  endtask

  task automatic load_flags(input logic [15:0] w);
    flags_wr_data = w; flags_wr_en = 1'b1; cyc(1); flags_wr_en = 1'b0;
  endtask

  task automatic check_outputs(input logic [3:0] ep, input string tag);
    chk(pend_vec, ep, tag);
    chk(req_valid, |ep, {tag, " valid R10"});
    if (|ep) chk(req_kind, exp_kind(ep), {tag, " kind R10"});
  endtask

  initial begin
    void'($urandom(32'd1234));
    cyc(3); rst_n = 1'b1; cyc(2);
    // R1 reset state
    check_outputs(4'b0000, "R1 idle");
    chk(flags_q, 16'h0000, "R1 flags");

    // R2 synchroniser latency on abort
    pin_abt_n = 1'b0; @(posedge clk); @(negedge clk);
    chk(pend_vec[1], 1'b0, "R2 after one edge");
    @(posedge clk); @(negedge clk);
    chk(pend_vec[1], 1'b1, "R2 after two edges R9");
    pin_abt_n = 1'b1; cyc(3);

    // R3 reset pin level
    pin_rst_n = 1'b0; cyc(3);
    check_outputs(4'b0001, "R3 reset level");
    pin_rst_n = 1'b1; cyc(3);

    // R7 R8 mask gating and restore
    pin_irq_n = 1'b0; cyc(3);
    check_outputs(4'b0000, "R7 masked held off");
    load_flags(16'hA5A4); cyc(1);
    chk(flags_q, 16'hA5A4, "R8 load word");
    check_outputs(4'b1000, "R7 irq taken");
    load_flags(16'hA5A0); cyc(1);
    check_outputs(4'b0000, "R8 restore masked");
    load_flags(16'hA5A4); cyc(1);

    // R9 abort over irq
    pin_abt_n = 1'b0; cyc(3);
    check_outputs(4'b1010, "R9 abort with irq");
    pin_abt_n = 1'b1; pin_irq_n = 1'b1; cyc(3);

    // R4 R5 NMI edge latch
    pin_nmi_n = 1'b0; cyc(4);
    check_outputs(4'b0100, "R4 nmi edge");
    pin_nmi_n = 1'b1; cyc(4);
    check_outputs(4'b0100, "R5 held after release");
    pin_nmi_n = 1'b0; cyc(4);
    ack_pulse(); cyc(4);
    check_outputs(4'b0000, "R4 one request per edge");
    pin_nmi_n = 1'b1; cyc(4);

    // R6 edge in ack cycle
    pin_nmi_n = 1'b0; cyc(4);
    pin_nmi_n = 1'b1; cyc(4);
    pin_nmi_n = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    ack_pulse();
    check_outputs(4'b0100, "R6 edge during ack");
    ack_pulse(); cyc(1);
    check_outputs(4'b0000, "R6 later ack clears");
    pin_nmi_n = 1'b1; cyc(4);

    // R11 reset clears latch and IE only, beats a load
    pin_nmi_n = 1'b0; cyc(4); pin_nmi_n = 1'b1;
    load_flags(16'h1234 | 16'h0004); cyc(1);
    pin_rst_n = 1'b0; cyc(2);
    load_flags(16'hFFFF); cyc(1);
    chk(flags_q, 16'hFFFB, "R11 ie cleared over load");
    check_outputs(4'b0001, "R11 latch cleared");
    pin_rst_n = 1'b1; cyc(3);
    check_outputs(4'b0000, "R11 after reset pin");

    // random rounds
    for (int it = 0; it < 300; it++) begin
      logic r, a, q, e, f;
      logic [15:0] w;
      logic [3:0] ep;
      r = $urandom_range(0, 3) == 0; a = $urandom_range(0, 1); q = $urandom_range(0, 1);
      e = $urandom_range(0, 1); f = $urandom_range(0, 1);
      w = 16'($urandom);
      w[2] = e;
      pin_rst_n = 1'b1; pin_abt_n = 1'b1; pin_irq_n = 1'b1; pin_nmi_n = 1'b1;
      cyc(4); ack_pulse();
      load_flags(w);
      pin_rst_n = ~r; pin_abt_n = ~a; pin_irq_n = ~q; pin_nmi_n = ~f;
      cyc(4);
      ep = {q & e & ~r, f & ~r, a, r};
      check_outputs(ep, "R10 random mix R7 R9 R11");
      chk(flags_q, r ? (w & 16'hFFFB) : w, "R8 random flags R11");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule